// File: doc/BRIEF.md
# Bandwidth-Adaptive Spatial Footprint Prefetcher

This block watches demand cache-line accesses. Each access carries a page number, a line offset inside a 4 KB page and a program-counter signature. The block keeps a small table of recently touched pages. For each tracked page it builds a 64-bit footprint. Bit k of the footprint means that the line k positions after the first (trigger) access to the page, counting modulo 64, was touched. Because the footprint is stored relative to the trigger, one learned shape fits any starting offset.

When a tracked page is evicted, its footprint trains a pattern table. The table is indexed by a 4-bit fold of the signature and holds two patterns for each index. The broad pattern collects every line seen in any footprint. The narrow pattern keeps only the lines seen in every footprint. When a page is touched for the first time, the block picks the broad pattern, the narrow pattern or nothing, according to a 2-bit memory-bandwidth utilisation quartile. It rotates the chosen pattern back to absolute offsets and issues prefetch line addresses one per cycle over a valid/ready handshake.

The block sits beside a cache controller. It takes the controller's demand stream and its bandwidth estimate, and returns line addresses to prefetch.

Top module: `footprint_prefetcher`

## Requirements
- R1: After reset, `pf_valid` is low and every pattern entry is invalid, so a trigger produces no requests until training has happened.
- R2: An access to a tracked page sets footprint bit (offset − trigger offset) mod 64 of that page. Offsets below the trigger wrap to high bit positions.
- R3: The first footprint trained into an invalid pattern entry becomes both the broad and the narrow pattern of that entry, and the entry becomes valid.
- R4: Training a valid entry replaces its broad pattern with the bitwise OR of the stored pattern and the footprint.
- R5: Training a valid entry replaces its narrow pattern with the bitwise AND of the stored pattern and the footprint.
- R6: At a trigger, quartile 0 or 1 selects the broad pattern and quartile 2 selects the narrow pattern. Quartile 3 issues no requests.
- R7: A trigger at offset t whose selected relative pattern has bit k set (k ≠ 0) requests line (t + k) mod 64 of the trigger's page. Requests leave in ascending absolute offset order, and the trigger line itself is never requested. `pf_addr` is {page, offset}, with the offset in the low 6 bits.
- R8: A request is held stable on `pf_addr` with `pf_valid` high until `pf_ready` is high. At most one request completes per cycle.
- R9: A new trigger discards the remaining requests of the current burst. The new burst is visible in the cycle after the trigger, even if a handshake completed in the trigger cycle.
- R10: An access to an already tracked page produces no request and leaves the pending burst unchanged, apart from a handshake completing in that cycle.
- R11: The tracker holds 8 pages. An access to an untracked page replaces the oldest allocated entry, and that entry's footprint trains the pattern entry at the fold of its signature. The fold is the XOR of the signature's 4-bit groups.
- R12: The pattern lookup at a trigger uses the table contents from before any training caused by the same trigger. An invalid entry yields no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Demand access present this cycle |
| acc_page | input | PAGE_W | Page number of the access |
| acc_offset | input | 6 | Line offset within the page |
| acc_sig | input | SIG_W | Program-counter signature |
| bw_quartile | input | 2 | Memory bandwidth utilisation quartile |
| pf_ready | input | 1 | Consumer accepts the current request |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | PAGE_W+6 | Line address of the offered request |

## Verification
A trigger sampled at one rising edge loads the new burst at that same edge, so the first request is due on `pf_addr` in the following cycle. Each accepted request is replaced by the next one one edge after its handshake. Footprint updates and training are not visible directly. They show up only at a later trigger that uses the same signature fold, so the directed sequences train, evict and then re-trigger before comparing. The bench drives inputs and samples outputs at the falling edge, and compares against a reference model that has been advanced by exactly one edge per cycle.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int PAGE_BYTES = 4096;
  localparam int LINE_BYTES = 64;
  localparam int LINES      = PAGE_BYTES / LINE_BYTES;
  localparam int OFF_W      = $clog2(LINES);
  localparam int HASH_W     = 4;

  typedef logic [LINES-1:0] footprint_t;
  typedef logic [OFF_W-1:0] line_off_t;
  typedef logic [HASH_W-1:0] hash_t;

  // rotate a relative footprint up by s positions (relative -> absolute)
  function automatic footprint_t rot_left(footprint_t v, line_off_t s);
    logic [2*LINES-1:0] d;
    d = {v, v} << s;
    return d[2*LINES-1:LINES];
  endfunction

  // single footprint bit for offset off relative to trigger trig
  function automatic footprint_t anchor_bit(line_off_t off, line_off_t trig);
    line_off_t d;
    d = off - trig;
    return footprint_t'(1) << d;
  endfunction

  // fold a signature into HASH_W bits by XOR
  function automatic hash_t fold_sig(logic [63:0] s);
    hash_t h;
    h = '0;
    for (int i = 0; i < 64; i++) h[i % HASH_W] ^= s[i];
    return h;
  endfunction

  // position of lowest set bit (0 for empty mask)
  function automatic line_off_t low_index(footprint_t m);
    line_off_t r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--) if (m[i]) r = line_off_t'(i);
    return r;
  endfunction
endpackage

// File: rtl/fp_page_tracker.sv
module fp_page_tracker
  import fp_pkg::*;
#(
  parameter int PAGE_W  = 24,
  parameter int SIG_W   = 12,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [PAGE_W-1:0] acc_page,
  input  line_off_t         acc_offset,
  input  logic [SIG_W-1:0]  acc_sig,
  output logic [ENTRIES-1:0] hit_vec,
  output logic              hit,
  output logic              alloc,
  output logic              victim_valid,
  output logic [SIG_W-1:0]  victim_sig,
  output footprint_t        victim_map
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] e_vld;
  logic [PAGE_W-1:0]  e_page [ENTRIES];
  logic [SIG_W-1:0]   e_sig  [ENTRIES];
  line_off_t          e_trig [ENTRIES];
  footprint_t         e_map  [ENTRIES];
  logic [PTR_W-1:0]   ptr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = e_vld[g] && (e_page[g] == acc_page);
  end

  assign hit          = acc_valid && (|hit_vec);
  assign alloc        = acc_valid && !(|hit_vec);
  assign victim_valid = e_vld[ptr];
  assign victim_sig   = e_sig[ptr];
  assign victim_map   = e_map[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      e_vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_page[i] <= '0;
        e_sig[i]  <= '0;
        e_trig[i] <= '0;
        e_map[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc && ptr == PTR_W'(i)) begin
          e_vld[i]  <= 1'b1;
          e_page[i] <= acc_page;
          e_sig[i]  <= acc_sig;
          e_trig[i] <= acc_offset;
          e_map[i]  <= footprint_t'(1);
        end else if (acc_valid && hit_vec[i]) begin
          e_map[i] <= e_map[i] | anchor_bit(acc_offset, e_trig[i]);
        end
      end
      if (alloc) ptr <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/fp_pattern_table.sv
module fp_pattern_table
  import fp_pkg::*;
#(
  parameter int SIG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SIG_W-1:0] look_sig,
  input  logic [1:0]       bw_quartile,
  output footprint_t       look_pat,
  input  logic             train_en,
  input  logic [SIG_W-1:0] train_sig,
  input  footprint_t       train_map
);
  localparam int ENTRIES = 1 << HASH_W;

  logic [ENTRIES-1:0] p_vld;
  footprint_t         p_broad  [ENTRIES];
  footprint_t         p_narrow [ENTRIES];
  hash_t              look_idx, train_idx;

  assign look_idx  = fold_sig(64'(look_sig));
  assign train_idx = fold_sig(64'(train_sig));

  always_comb begin
    look_pat = '0;
    if (p_vld[look_idx]) begin
      unique case (bw_quartile)
        2'd0, 2'd1: look_pat = p_broad[look_idx];
        2'd2:       look_pat = p_narrow[look_idx];
        default:    look_pat = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        p_broad[i]  <= '0;
        p_narrow[i] <= '0;
      end
    end else if (train_en) begin
      p_vld[train_idx] <= 1'b1;
      if (!p_vld[train_idx]) begin
        p_broad[train_idx]  <= train_map;
        p_narrow[train_idx] <= train_map;
      end else begin
        p_broad[train_idx]  <= p_broad[train_idx] | train_map;
        p_narrow[train_idx] <= p_narrow[train_idx] & train_map;
      end
    end
  end
endmodule

// File: rtl/fp_burst_issuer.sv
module fp_burst_issuer
  import fp_pkg::*;
#(
  parameter int PAGE_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [PAGE_W-1:0]       load_page,
  input  footprint_t              load_mask,
  input  logic                    pf_ready,
  output logic                    pf_valid,
  output logic [PAGE_W+OFF_W-1:0] pf_addr,
  output logic                    fire
);
  footprint_t        mask;
  logic [PAGE_W-1:0] page;
  line_off_t         cur;

  assign cur      = low_index(mask);
  assign pf_valid = |mask;
  assign pf_addr  = {page, cur};
  assign fire     = pf_valid && pf_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      page <= '0;
    end else if (load) begin
      mask <= load_mask;
      page <= load_page;
    end else if (fire) begin
      mask[cur] <= 1'b0;
    end
  end
endmodule

// File: rtl/footprint_prefetcher.sv
module footprint_prefetcher
  import fp_pkg::*;
#(
  parameter int PAGE_W        = 24,
  parameter int SIG_W         = 12,
  parameter int TRACK_ENTRIES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic [PAGE_W-1:0]       acc_page,
  input  logic [OFF_W-1:0]        acc_offset,
  input  logic [SIG_W-1:0]        acc_sig,
  input  logic [1:0]              bw_quartile,
  input  logic                    pf_ready,
  output logic                    pf_valid,
  output logic [PAGE_W+OFF_W-1:0] pf_addr
);
  logic [TRACK_ENTRIES-1:0] hit_vec;
  logic                     track_hit, trigger_evt, train_evt, issue_fire;
  logic                     victim_valid;
  logic [SIG_W-1:0]         victim_sig;
  footprint_t               victim_map, look_pat, burst_mask;

  fp_page_tracker #(.PAGE_W(PAGE_W), .SIG_W(SIG_W), .ENTRIES(TRACK_ENTRIES)) u_track (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_page(acc_page),
    .acc_offset(acc_offset), .acc_sig(acc_sig), .hit_vec(hit_vec), .hit(track_hit),
    .alloc(trigger_evt), .victim_valid(victim_valid), .victim_sig(victim_sig),
    .victim_map(victim_map)
  );

  assign train_evt = trigger_evt && victim_valid;

  fp_pattern_table #(.SIG_W(SIG_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .look_sig(acc_sig), .bw_quartile(bw_quartile),
    .look_pat(look_pat), .train_en(train_evt), .train_sig(victim_sig),
    .train_map(victim_map)
  );

  // relative pattern back to absolute offsets, trigger line removed
  assign burst_mask = rot_left(look_pat, acc_offset) & ~(footprint_t'(1) << acc_offset);

  fp_burst_issuer #(.PAGE_W(PAGE_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .load(trigger_evt), .load_page(acc_page),
    .load_mask(burst_mask), .pf_ready(pf_ready), .pf_valid(pf_valid),
    .pf_addr(pf_addr), .fire(issue_fire)
  );
endmodule

// File: rtl/footprint_prefetcher_checker.sv
module footprint_prefetcher_checker
  import fp_pkg::*;
#(
  parameter int PAGE_W        = 24,
  parameter int TRACK_ENTRIES = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [OFF_W-1:0]         acc_offset,
  input logic [1:0]               bw_quartile,
  input logic                     pf_valid,
  input logic                     pf_ready,
  input logic [PAGE_W+OFF_W-1:0]  pf_addr,
  input logic                     trigger_evt,
  input logic                     track_hit,
  input logic                     issue_fire,
  input logic [TRACK_ENTRIES-1:0] hit_vec
);
  localparam int AW = PAGE_W + OFF_W;

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !pf_valid);

  assert_quartile3_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trigger_evt && bw_quartile == 2'd3 |=> !pf_valid);

  assert_skip_trigger_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trigger_evt |=> !pf_valid || pf_addr[OFF_W-1:0] != $past(acc_offset));

  assert_ascending_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire && !trigger_evt |=> !pf_valid ||
      (pf_addr[OFF_W-1:0] > $past(pf_addr[OFF_W-1:0]) &&
       pf_addr[AW-1:OFF_W] == $past(pf_addr[AW-1:OFF_W])));

  assert_hold_until_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready && !trigger_evt |=> pf_valid && $stable(pf_addr));

  assert_hit_keeps_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    track_hit && !issue_fire |=> pf_valid == $past(pf_valid) && $stable(pf_addr));

  assert_single_page_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

bind footprint_prefetcher footprint_prefetcher_checker #(
  .PAGE_W(PAGE_W), .TRACK_ENTRIES(TRACK_ENTRIES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_offset(acc_offset), .bw_quartile(bw_quartile),
  .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
  .trigger_evt(trigger_evt), .track_hit(track_hit), .issue_fire(issue_fire),
  .hit_vec(hit_vec)
);

// File: tb/tb_footprint_prefetcher.sv
`timescale 1ns/1ps
module tb_footprint_prefetcher;
  localparam int PW = 24;
  localparam int SW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [PW-1:0] acc_page = '0;
  logic [5:0]    acc_offset = '0;
  logic [SW-1:0] acc_sig = '0;
  logic [1:0]    bw_quartile = '0;
  logic          pf_ready = 1'b0;
  logic          pf_valid;
  logic [PW+5:0] pf_addr;

  footprint_prefetcher #(.PAGE_W(PW), .SIG_W(SW), .TRACK_ENTRIES(8)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_page(acc_page),
    .acc_offset(acc_offset), .acc_sig(acc_sig), .bw_quartile(bw_quartile),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  string tag = "R1";
  logic [1:0] q_bw = 0;
  bit    q_rdy = 0;

  // reference model
  logic [PW-1:0] trk_q[$];
  logic [SW-1:0] t_sig[logic [PW-1:0]];
  int            t_trig[logic [PW-1:0]];
  logic [63:0]   t_map[logic [PW-1:0]];
  logic [63:0]   m_broad[16];
  logic [63:0]   m_narrow[16];
  bit            m_vld[16];
  int            pend[$];
  logic [PW-1:0] pend_page = '0;

  function automatic int sig_hash(logic [SW-1:0] s);
    return int'(s[3:0] ^ s[7:4] ^ s[11:8]);
  endfunction

  task automatic check(bit ok, string what, logic [PW+5:0] act, logic [PW+5:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(bit v, logic [PW-1:0] pg, int off, logic [SW-1:0] sg);
    bit fire = (pend.size() > 0) && q_rdy;
    if (v && t_map.exists(pg)) begin
      t_map[pg] |= 64'd1 << ((off - t_trig[pg]) & 63);
      if (fire) void'(pend.pop_front());
    end else if (v) begin
      int h = sig_hash(sg);
      logic [63:0] pat = '0;
      int newp[$];
      if (q_bw != 2'd3 && m_vld[h]) pat = (q_bw < 2) ? m_broad[h] : m_narrow[h];
      for (int j = 0; j < 64; j++) begin
        int rb = (j - off) & 63;
        if (rb != 0 && pat[rb]) newp.push_back(j);
      end
      if (trk_q.size() == 8) begin
        logic [PW-1:0] vp = trk_q.pop_front();
        int vh = sig_hash(t_sig[vp]);
        if (!m_vld[vh]) begin
          m_broad[vh] = t_map[vp];
          m_narrow[vh] = t_map[vp];
          m_vld[vh] = 1;
        end else begin
          m_broad[vh] |= t_map[vp];
          m_narrow[vh] &= t_map[vp];
        end
        t_sig.delete(vp); t_trig.delete(vp); t_map.delete(vp);
      end
      trk_q.push_back(pg);
      t_sig[pg] = sg; t_trig[pg] = off; t_map[pg] = 64'd1;
      pend = newp;
      pend_page = pg;
    end else if (fire) begin
      void'(pend.pop_front());
    end
  endtask

  // one cycle: compare at falling edge, then drive and advance the model
  task automatic step(bit v, logic [PW-1:0] pg, int off, logic [SW-1:0] sg);
    logic [PW+5:0] exp_a;
    @(negedge clk);
    check(pf_valid == (pend.size() > 0), "pf_valid", PW+6'(pf_valid), PW+6'(pend.size() > 0));
    if (pend.size() > 0) begin
      exp_a = {pend_page, 6'(pend[0])};
      check(pf_addr == exp_a, "pf_addr", pf_addr, exp_a);
    end
    acc_valid = v; acc_page = pg; acc_offset = 6'(off); acc_sig = sg;
    bw_quartile = q_bw; pf_ready = q_rdy;
    model(v, pg, off, sg);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, '0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_vld[i] = 0; m_broad[i] = '0; m_narrow[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; q_rdy = 1; idle(3);
    // untrained signature: nothing issued
    tag = "R12"; q_bw = 0;
    step(1, 24'h100, 5, 12'h001); idle(2);
    // footprint with a wrapped bit (3 - 5 -> 62)
    tag = "R2";
    step(1, 24'h100, 7, 12'h001); step(1, 24'h100, 9, 12'h001);
    step(1, 24'h100, 3, 12'h001); idle(2);
    // evict by filling with other folds
    tag = "R11";
    for (int i = 0; i < 8; i++) step(1, 24'h200 + PW'(i), i, 12'(32'h020 + 32'h010 * i));
    idle(3);
    tag = "R3";
    step(1, 24'h300, 10, 12'h001); idle(5);
    step(1, 24'h300, 12, 12'h001); step(1, 24'h300, 20, 12'h001);
    for (int i = 0; i < 9; i++) step(1, 24'h400 + PW'(i), 2 * i, 12'(32'h020 + 32'h010 * (i % 8)));
    idle(3);
    tag = "R4"; q_bw = 1;
    step(1, 24'h500, 0, 12'h001); idle(6);
    tag = "R5"; q_bw = 2;
    step(1, 24'h501, 60, 12'h001); idle(3);
    tag = "R6"; q_bw = 3;
    step(1, 24'h502, 1, 12'h001); idle(2);
    q_bw = 0; step(1, 24'h503, 40, 12'h001); idle(1);
    tag = "R8"; q_rdy = 0;
    step(1, 24'h504, 30, 12'h001); idle(4);
    q_rdy = 1; idle(5);
    tag = "R9"; q_rdy = 0;
    step(1, 24'h505, 8, 12'h001); idle(2);
    q_rdy = 1; step(1, 24'h506, 50, 12'h001);
    step(1, 24'h507, 20, 12'h001); idle(5);
    tag = "R10";
    step(1, 24'h508, 2, 12'h001); q_rdy = 0;
    step(1, 24'h508, 9, 12'h001); step(1, 24'h507, 4, 12'h001);
    q_rdy = 1; step(1, 24'h508, 63, 12'h001); idle(5);
    tag = "R7";
    step(1, 24'h509, 63, 12'h001); idle(6);
    tag = "R11";
    for (int n = 0; n < 4000; n++) begin
      logic [SW-1:0] sg;
      case ($urandom_range(0, 3))
        0: sg = 12'h001; 1: sg = 12'h020; 2: sg = 12'h0f0; default: sg = 12'h111;
      endcase
      q_bw = 2'($urandom_range(0, 3));
      q_rdy = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 2) != 0)
        step(1, 24'h600 + PW'($urandom_range(0, 11)), $urandom_range(0, 63), sg);
      else
        idle(1);
    end
    idle(3);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule